// File: doc/BRIEF.md
# Immediate-Operand Integer Execution Stage

This block executes the four 32-bit immediate-form integer operations of a simple load/store processor: add-immediate-unsigned (wrapping add), set-if-less-than-immediate-unsigned, or-immediate and load-upper-immediate. Each clock it takes one instruction word and the value of its first source register. It returns the register address to read that value from, and one cycle later a registered result, the destination register index, a write enable and an illegal-opcode flag.

The decode splits the word into fixed fields. The stage then extends the 16-bit immediate in the way each operation needs: sign extension for the add and the unsigned compare, zero extension for the OR, and placement in the upper half for load-upper. The extended value feeds a small arithmetic and selection stage, and the outcome is held in an output register. The register file, memory, control flow and all other formats are outside this block. A load-upper followed by an or-immediate into the same register builds any 32-bit constant.

Top module: `ifx_exec_unit`

## Requirements
- R1: Field positions are fixed: opcode in instruction bits 31:26, source register index in bits 25:21 (driven combinationally on `rs_addr_o`), target register index in bits 20:16 (reported on `dest_o` for legal opcodes), immediate in bits 15:0.
- R2: Opcode 6'd9 (add-immediate) yields `rs_val_i` plus the sign-extended immediate, modulo 2^32, with no overflow indication.
- R3: Opcode 6'd11 (set-less-than-immediate, unsigned) sign-extends the immediate to 32 bits, then yields 32'd1 when `rs_val_i` is below it as unsigned numbers and 32'd0 otherwise.
- R4: Opcode 6'd13 (or-immediate) yields `rs_val_i` ORed with the zero-extended immediate.
- R5: Opcode 6'd15 (load-upper) yields the immediate in result bits 31:16 and zero in bits 15:0; `rs_val_i` has no effect.
- R6: Any other opcode sets `illegal_o`, clears `wr_en_o`, and drives `result_o` and `dest_o` to zero.
- R7: A legal instruction whose target index is 0 keeps `wr_en_o` low; the result is still reported; otherwise `wr_en_o` is high for legal opcodes.
- R8: `result_o`, `dest_o`, `wr_en_o` and `illegal_o` are registered: they reflect the instruction present before the most recent rising clock edge and are all zero during and right after reset.
- R9: A load-upper of 0xABAB followed by an or-immediate of 0xCDCD on the produced value gives 0xABABCDCD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the source register |
| rs_addr_o | output | 5 | Source register index, combinational from `instr_i` |
| result_o | output | 32 | Registered result |
| dest_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered register write enable |
| illegal_o | output | 1 | Registered unsupported-opcode flag |

## Verification
The source index is combinational, so the bench checks it a short delay after driving the word at the falling edge. Every other output arrives after exactly one rising edge. The bench samples those one time unit after that edge, and it also checks just before the edge that they still hold the previous instruction's values. A sweep covers all 64 opcodes against boundary and random operands, including immediates 0x7FFF, 0x8000 and 0xFFFF, with the expected values computed in plain arithmetic in the bench.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

    localparam int OPC_W  = 6;
    localparam int REG_AW = 5;
    localparam int IMM_W  = 16;

    localparam logic [OPC_W-1:0] OPC_ADD_IMM  = 6'd9;
    localparam logic [OPC_W-1:0] OPC_LTU_IMM  = 6'd11;
    localparam logic [OPC_W-1:0] OPC_OR_IMM   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_HIGH_IMM = 6'd15;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADD  = 3'd1,
        OP_LTU  = 3'd2,
        OP_OR   = 3'd3,
        OP_HIGH = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        EXT_SIGN = 2'd0,
        EXT_ZERO = 2'd1,
        EXT_HIGH = 2'd2
    } ext_e;

    typedef struct packed {
        op_e               op;
        ext_e              ext;
        logic              illegal;
        logic [REG_AW-1:0] src;
        logic [REG_AW-1:0] tgt;
        logic [IMM_W-1:0]  imm;
    } dec_t;

endpackage

// File: rtl/ifx_field_split.sv
module ifx_field_split
    import ifx_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int SRC_LSB = OPC_LSB - REG_AW;
    localparam int TGT_LSB = SRC_LSB - REG_AW;

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc         = instr[INSTR_W-1:OPC_LSB];
        dec.src     = instr[OPC_LSB-1:SRC_LSB];
        dec.tgt     = instr[SRC_LSB-1:TGT_LSB];
        dec.imm     = instr[IMM_W-1:0];
        dec.op      = OP_NONE;
        dec.ext     = EXT_SIGN;
        dec.illegal = 1'b0;
        case (opc)
            OPC_ADD_IMM: begin
                dec.op  = OP_ADD;
                dec.ext = EXT_SIGN;
            end
            OPC_LTU_IMM: begin
                dec.op  = OP_LTU;
                dec.ext = EXT_SIGN;
            end
            OPC_OR_IMM: begin
                dec.op  = OP_OR;
                dec.ext = EXT_ZERO;
            end
            OPC_HIGH_IMM: begin
                dec.op  = OP_HIGH;
                dec.ext = EXT_HIGH;
            end
            default: begin
                dec.op      = OP_NONE;
                dec.illegal = 1'b1;
            end
        endcase
    end

    // R6: decode flags exactly the non-listed opcodes
    always_comb begin
        a_r6_decode_flag: assert ((dec.op == OP_NONE) == dec.illegal);
    end

endmodule

// File: rtl/ifx_imm_ext.sv
module ifx_imm_ext
    import ifx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  ext_e              mode,
    output logic [DATA_W-1:0] ext
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        case (mode)
            EXT_SIGN: ext = {{PAD_W{imm[IMM_W-1]}}, imm};
            EXT_ZERO: ext = {{PAD_W{1'b0}}, imm};
            EXT_HIGH: ext = {imm, {PAD_W{1'b0}}};
            default:  ext = '0;
        endcase
    end

endmodule

// File: rtl/ifx_result_mux.sv
module ifx_result_mux
    import ifx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] ext_imm,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] sum;
    logic              below;

    always_comb begin
        sum   = rs_val + ext_imm;
        below = (rs_val < ext_imm);
        case (op)
            OP_ADD:  res = sum;
            OP_LTU:  res = {{(DATA_W-1){1'b0}}, below};
            OP_OR:   res = rs_val | ext_imm;
            OP_HIGH: res = ext_imm;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/ifx_exec_unit.sv
module ifx_exec_unit
    import ifx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  rs_val_i,
    output logic [REG_AW-1:0]  rs_addr_o,
    output logic [DATA_W-1:0]  result_o,
    output logic [REG_AW-1:0]  dest_o,
    output logic               wr_en_o,
    output logic               illegal_o
);
    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int HALF_PAD = DATA_W - IMM_W;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [REG_AW-1:0] dest;
        logic              wr_en;
        logic              illegal;
        logic              seen;
    } stage_t;

    dec_t              dec;
    logic [DATA_W-1:0] ext_imm;
    logic [DATA_W-1:0] alu_res;
    stage_t            stage_d, stage_q;

    ifx_field_split #(.INSTR_W(INSTR_W)) u_split (
        .instr (instr_i),
        .dec   (dec)
    );

    ifx_imm_ext #(.DATA_W(DATA_W)) u_ext (
        .imm  (dec.imm),
        .mode (dec.ext),
        .ext  (ext_imm)
    );

    ifx_result_mux #(.DATA_W(DATA_W)) u_mux (
        .op      (dec.op),
        .rs_val  (rs_val_i),
        .ext_imm (ext_imm),
        .res     (alu_res)
    );

    always_comb begin
        stage_d.seen    = 1'b1;
        stage_d.illegal = dec.illegal;
        if (dec.illegal) begin
            stage_d.result = '0;
            stage_d.dest   = '0;
            stage_d.wr_en  = 1'b0;
        end else begin
            stage_d.result = alu_res;
            stage_d.dest   = dec.tgt;
            stage_d.wr_en  = (dec.tgt != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign rs_addr_o = dec.src;
    assign result_o  = stage_q.result;
    assign dest_o    = stage_q.dest;
    assign wr_en_o   = stage_q.wr_en;
    assign illegal_o = stage_q.illegal;

    // R6: an unsupported opcode never writes
    a_r6_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && result_o == '0 && dest_o == '0));

    // R7: register 0 is never written
    a_r7_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (dest_o != '0));

    // R2: wrapping add of the sign-extended immediate, one cycle later
    a_r2_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.seen && $past(instr_i[INSTR_W-1:OPC_LSB]) == OPC_ADD_IMM) |->
        (result_o == $past(rs_val_i) +
            {{HALF_PAD{$past(instr_i[IMM_W-1])}}, $past(instr_i[IMM_W-1:0])}));

    // R3: unsigned compare yields only 0 or 1
    a_r3_ltu_bool: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.seen && $past(instr_i[INSTR_W-1:OPC_LSB]) == OPC_LTU_IMM) |->
        (result_o[DATA_W-1:1] == '0));

    // R5: load-upper clears the low half and holds the immediate high
    a_r5_high_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q.seen && $past(instr_i[INSTR_W-1:OPC_LSB]) == OPC_HIGH_IMM) |->
        (result_o[IMM_W-1:0] == '0 &&
         result_o[DATA_W-1:DATA_W-IMM_W] == $past(instr_i[IMM_W-1:0])));

    // R8: flags are all clear until the first instruction is registered
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_q.seen |-> (!wr_en_o && !illegal_o));

endmodule

// File: tb/ifx_exec_unit_tb.sv
`timescale 1ns/100ps
module ifx_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [4:0]  rs_addr_o;
    logic [31:0] result_o;
    logic [4:0]  dest_o;
    logic        wr_en_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] prev_res = '0;
    logic [4:0]  prev_dest = '0;
    logic        prev_we = 1'b0;
    logic        prev_ill = 1'b0;

    always #2.5 clk = ~clk;

    ifx_exec_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr_i),
        .rs_val_i  (rs_val_i),
        .rs_addr_o (rs_addr_o),
        .result_o  (result_o),
        .dest_o    (dest_o),
        .wr_en_o   (wr_en_o),
        .illegal_o (illegal_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [5:0] opc);
        case (opc)
            6'd9:    return "R2 add-immediate";
            6'd11:   return "R3 less-than-unsigned";
            6'd13:   return "R4 or-immediate";
            6'd15:   return "R5 load-upper";
            default: return "R6 illegal opcode";
        endcase
    endfunction

    task automatic issue(input logic [5:0] opc, input logic [4:0] rs, input logic [4:0] rt,
                         input logic [15:0] imm, input logic [31:0] rsv,
                         output logic [31:0] got);
        logic [31:0] sx, exp_res;
        logic        legal;
        sx = (imm >= 16'h8000) ? (32'(imm) + 32'hFFFF0000) : 32'(imm);
        legal = 1'b1;
        case (opc)
            6'd9:    exp_res = rsv + sx;
            6'd11:   exp_res = (rsv < sx) ? 32'd1 : 32'd0;
            6'd13:   exp_res = rsv | 32'(imm);
            6'd15:   exp_res = 32'(imm) * 32'd65536;
            default: begin exp_res = 32'd0; legal = 1'b0; end
        endcase
        @(negedge clk);
        instr_i  = {opc, rs, rt, imm};
        rs_val_i = rsv;
        #1;
        check(rs_addr_o == rs, "R1 source index", 32'(rs_addr_o), 32'(rs));
        check(result_o == prev_res && wr_en_o == prev_we && illegal_o == prev_ill && dest_o == prev_dest,
              "R8 outputs held until edge", result_o, prev_res);
        @(posedge clk);
        #1;
        check(result_o == exp_res, req_of(opc), result_o, exp_res);
        check(illegal_o == !legal, "R6 illegal flag", 32'(illegal_o), 32'(!legal));
        check(dest_o == (legal ? rt : 5'd0), "R1 destination index", 32'(dest_o), 32'(legal ? rt : 5'd0));
        check(wr_en_o == (legal && rt != 5'd0), "R7 write enable", 32'(wr_en_o), 32'(legal && rt != 5'd0));
        prev_res  = exp_res;
        prev_dest = legal ? rt : 5'd0;
        prev_we   = legal && rt != 5'd0;
        prev_ill  = !legal;
        got = result_o;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rs_set [8];
        logic [15:0] imm_set [6];
        logic [31:0] got;

        instr_i  = {6'd15, 5'd1, 5'd2, 16'hFFFF};
        rs_val_i = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        check(result_o == 0 && dest_o == 0 && !wr_en_o && !illegal_o,
              "R8 reset state", result_o, 32'd0);
        @(negedge clk);
        instr_i = {6'd0, 5'd0, 5'd0, 16'h0000};
        rst_n   = 1'b1;
        @(posedge clk);
        #1;
        prev_res = 0; prev_dest = 0; prev_we = 0; prev_ill = 1'b1;
        check(illegal_o == 1'b1, "R6 first opcode zero", 32'(illegal_o), 32'd1);

        rs_set[0] = 32'h0000_0000; rs_set[1] = 32'h0000_0001;
        rs_set[2] = 32'h0000_7FFF; rs_set[3] = 32'hFFFF_8000;
        rs_set[4] = 32'hFFFF_FFFF; rs_set[5] = 32'h8000_0000;
        rs_set[6] = 32'h7FFF_FFFF; rs_set[7] = 32'h1234_5678;
        imm_set[0] = 16'h0000; imm_set[1] = 16'h0001; imm_set[2] = 16'h7FFF;
        imm_set[3] = 16'h8000; imm_set[4] = 16'hFFFF; imm_set[5] = 16'h5A3C;

        for (int op = 0; op < 64; op++) begin
            for (int r = 0; r < 8; r++) begin
                for (int m = 0; m < 6; m++) begin
                    for (int t = 0; t < 2; t++) begin
                        issue(6'(op), 5'(r * 3 + m), (t == 0) ? 5'd0 : 5'(1 + ((r + m + op) % 31)),
                              imm_set[m], rs_set[r], got);
                    end
                end
            end
        end

        for (int k = 0; k < 400; k++) begin
            logic [31:0] rnd;
            rnd = $urandom;
            issue((k % 2 == 0) ? 6'd9 : ((k % 4 == 1) ? 6'd11 : 6'd13), rnd[25:21], rnd[20:16],
                  rnd[15:0], $urandom, got);
        end

        // R9: constant built from two halves
        issue(6'd15, 5'd0, 5'd8, 16'hABAB, 32'hDEAD_BEEF, got);
        issue(6'd13, 5'd8, 5'd8, 16'hCDCD, got, got);
        check(got == 32'hABAB_CDCD, "R9 constant build", got, 32'hABAB_CDCD);

        // R3: boundary compares spelled out
        issue(6'd11, 5'd3, 5'd4, 16'hFFFF, 32'hFFFF_FFFE, got);
        check(got == 32'd1, "R3 below all-ones", got, 32'd1);
        issue(6'd11, 5'd3, 5'd4, 16'h8000, 32'h7FFF_FFFF, got);
        check(got == 32'd1, "R3 large unsigned bound", got, 32'd1);
        issue(6'd11, 5'd3, 5'd4, 16'h7FFF, 32'h0000_7FFF, got);
        check(got == 32'd0, "R3 equal not below", got, 32'd0);

        // R2: wrap without overflow signalling
        issue(6'd9, 5'd3, 5'd4, 16'h0001, 32'hFFFF_FFFF, got);
        check(got == 32'd0 && !illegal_o, "R2 wrap to zero", got, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule